// File: doc/BRIEF.md
# Structured Lane Permute with Fused Add

This block takes two vectors of lanes, operand A and operand B, where every lane holds one data word. It moves the lanes of B according to one of a small set of structured patterns, and can then add the moved B to A lane by lane in the same cycle. The lanes are grouped into rows of 16. A row splits into two octets of 8 lanes and into four quads of 4 lanes. Every pattern is built from these groups: selection inside a quad, shifts and rotates inside a row, broadcasts and mirrors inside a row or octet, broadcasts from one row into the next, and one-lane moves across the whole vector.

Callers use it as the operand stage of a vector ALU. A pattern code and an 8-bit argument pick the movement. A fuse flag chooses between the sum A + moved B and the moved B alone. The result is registered, so it appears on the clock edge after the input is marked valid. When no new input arrives, the register keeps its value.

Top module: `lanePermAdd`

## Requirements
- R1: While rstN is low, result is all zeros and outValid is 0.
- R2: A set of inputs presented with inValid high appears on result on the next rising edge, and outValid is high for that cycle. While inValid is low, result keeps its value and outValid goes low.
- R3: Pattern code 0 (quad select): output position k of each quad (k = 0..3) takes the quad lane given by patArg[2k+1:2k].
- R4: Code 1 (row shift up) gives lane p of a row the value of row lane p-n. Code 2 (row shift down) gives lane p the value of row lane p+n. Here n = patArg[3:0]. A lane whose source would fall outside its row keeps its own B value.
- R5: Code 3 (row rotate) gives lane p of a row the value of row lane (p-n) mod 16, with n = patArg[3:0].
- R6: Code 4 (row share) gives every lane of a row the value of that row's lane patArg[3:0].
- R7: Code 5 reverses lane order inside each row of 16. Code 6 reverses lane order inside each octet of 8.
- R8: Code 7 fills every lane of each row except the first with the value of the last lane of the row before it. Lanes of the first row keep their own value. Code 8 fills every lane of the upper half of the vector with the value of the last lane of the lower half. The lower half keeps its own values.
- R9: Code 9 (wave shift up) gives lane i the value of lane i-1, and lane 0 keeps its own value. Code 10 (wave shift down) gives lane i the value of lane i+1, and the top lane keeps its own value.
- R10: Code 11 (wave rotate up) works like code 9, but lane 0 takes the value of the top lane. Code 12 (wave rotate down) works like code 10, but the top lane takes the value of lane 0.
- R11: When fuseAdd is high, each result lane equals A plus the moved B, modulo 2^DATA_W. When fuseAdd is low, each result lane is the moved B alone.
- R12: Codes 13 to 15 pass B through unmoved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Inputs are valid this cycle |
| pattern | input | 4 | Pattern code |
| patArg | input | 8 | Pattern argument (quad selectors or amount/lane) |
| fuseAdd | input | 1 | Add the permuted B to A |
| aIn | input | NUM_ROWS*16*DATA_W | Operand A, lane i at bits [i*DATA_W +: DATA_W] |
| bIn | input | NUM_ROWS*16*DATA_W | Operand B, same layout |
| result | output | NUM_ROWS*16*DATA_W | Registered per-lane result |
| outValid | output | 1 | result was loaded on the last edge |

## Verification
The bench builds the block with its defaults: four rows of 16 lanes, which makes 64 lanes of 32 bits. Four rows are the smallest case in which the row-to-row broadcast, the half-vector broadcast and the wave moves across row seams are all separate from one another. Each lane of B holds a distinct value derived from its index, so any misrouted lane shows up as a wrong value. The 32-bit width lets an all-ones A operand check that the fused add wraps around.

// File: rtl/lanePermPkg.sv
package lanePermPkg;

  // Pattern codes; the numeric values are part of the block's interface.
  typedef enum logic [3:0] {
    PAT_QUAD      = 4'd0,
    PAT_ROW_UP    = 4'd1,
    PAT_ROW_DOWN  = 4'd2,
    PAT_ROW_ROT   = 4'd3,
    PAT_ROW_SHARE = 4'd4,
    PAT_ROW_MIRR  = 4'd5,
    PAT_OCT_MIRR  = 4'd6,
    PAT_BC_ROW    = 4'd7,
    PAT_BC_HALF   = 4'd8,
    PAT_WAVE_UP   = 4'd9,
    PAT_WAVE_DOWN = 4'd10,
    PAT_WAVE_RUP  = 4'd11,
    PAT_WAVE_RDN  = 4'd12,
    PAT_PASS13    = 4'd13,
    PAT_PASS14    = 4'd14,
    PAT_PASS15    = 4'd15
  } patSel_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic     capture;
    logic     addOn;
    patSel_e  pat;
    logic [7:0] arg;
  } permStrobe_t;

endpackage

// File: rtl/laneCtrl.sv
module laneCtrl
  import lanePermPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [3:0]  pattern,
  input  logic [7:0]  patArg,
  input  logic        fuseAdd,
  output permStrobe_t strobe,
  output logic        outValid
);

  always_comb begin
    strobe.capture = inValid;
    strobe.addOn   = fuseAdd;
    strobe.pat     = patSel_e'(pattern);
    strobe.arg     = patArg;
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

endmodule

// File: rtl/lanePermNet.sv
module lanePermNet
  import lanePermPkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NUM_ROWS = 4
) (
  input  patSel_e    pat,
  input  logic [7:0] arg,
  input  logic [NUM_ROWS*16*DATA_W-1:0] bVec,
  output logic [NUM_ROWS*16*DATA_W-1:0] permVec
);

  localparam int ROW_LEN = 16;
  localparam int LANES   = NUM_ROWS * ROW_LEN;
  localparam int HALF    = LANES / 2;
  localparam int IDX_W   = $clog2(LANES);

  for (genvar g = 0; g < LANES; g++) begin : gLane
    localparam int ROW_BASE = (g / ROW_LEN) * ROW_LEN;
    localparam int POS      = g % ROW_LEN;
    localparam int QBASE    = g - (g % 4);
    localparam int QPOS     = g % 4;
    localparam int OBASE    = g - (g % 8);
    localparam int OPOS     = g % 8;

    logic [IDX_W-1:0] srcIdx;

    always_comb begin
      int amt;
      int src;
      amt = int'(arg[3:0]);
      src = g;
      case (pat)
        PAT_QUAD:      src = QBASE + int'(arg[2*QPOS +: 2]);
        PAT_ROW_UP:    if (POS >= amt) src = g - amt;
        PAT_ROW_DOWN:  if (POS + amt < ROW_LEN) src = g + amt;
        PAT_ROW_ROT:   src = ROW_BASE + ((POS - amt + ROW_LEN) % ROW_LEN);
        PAT_ROW_SHARE: src = ROW_BASE + amt;
        PAT_ROW_MIRR:  src = ROW_BASE + ROW_LEN - 1 - POS;
        PAT_OCT_MIRR:  src = OBASE + 7 - OPOS;
        PAT_BC_ROW:    if (g >= ROW_LEN) src = ROW_BASE - 1;
        PAT_BC_HALF:   if (g >= HALF) src = HALF - 1;
        PAT_WAVE_UP:   if (g > 0) src = g - 1;
        PAT_WAVE_DOWN: if (g < LANES - 1) src = g + 1;
        PAT_WAVE_RUP:  src = (g + LANES - 1) % LANES;
        PAT_WAVE_RDN:  src = (g + 1) % LANES;
        default:       src = g;
      endcase
      srcIdx = IDX_W'(src);
    end

    assign permVec[g*DATA_W +: DATA_W] = bVec[int'(srcIdx)*DATA_W +: DATA_W];
  end

endmodule

// File: rtl/laneDatapath.sv
module laneDatapath
  import lanePermPkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NUM_ROWS = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  permStrobe_t strobe,
  input  logic [NUM_ROWS*16*DATA_W-1:0] aVec,
  input  logic [NUM_ROWS*16*DATA_W-1:0] bVec,
  output logic [NUM_ROWS*16*DATA_W-1:0] resVec
);

  localparam int LANES = NUM_ROWS * 16;
  localparam int VEC_W = LANES * DATA_W;

  logic [VEC_W-1:0] permVec;
  logic [VEC_W-1:0] nextVec;

  lanePermNet #(.DATA_W(DATA_W), .NUM_ROWS(NUM_ROWS)) uNet (
    .pat     (strobe.pat),
    .arg     (strobe.arg),
    .bVec    (bVec),
    .permVec (permVec)
  );

  for (genvar g = 0; g < LANES; g++) begin : gAdd
    logic [DATA_W-1:0] sumLane;
    assign sumLane = aVec[g*DATA_W +: DATA_W] + permVec[g*DATA_W +: DATA_W];
    assign nextVec[g*DATA_W +: DATA_W] =
      strobe.addOn ? sumLane : permVec[g*DATA_W +: DATA_W];
  end

  always_ff @(posedge clk) begin
    if (!rstN)               resVec <= '0;
    else if (strobe.capture) resVec <= nextVec;
  end

endmodule

// File: rtl/lanePermAdd.sv
module lanePermAdd
  import lanePermPkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NUM_ROWS = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic inValid,
  input  logic [3:0] pattern,
  input  logic [7:0] patArg,
  input  logic fuseAdd,
  input  logic [NUM_ROWS*16*DATA_W-1:0] aIn,
  input  logic [NUM_ROWS*16*DATA_W-1:0] bIn,
  output logic [NUM_ROWS*16*DATA_W-1:0] result,
  output logic outValid
);

  permStrobe_t strobe;

  laneCtrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .pattern  (pattern),
    .patArg   (patArg),
    .fuseAdd  (fuseAdd),
    .strobe   (strobe),
    .outValid (outValid)
  );

  laneDatapath #(.DATA_W(DATA_W), .NUM_ROWS(NUM_ROWS)) uData (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .aVec   (aIn),
    .bVec   (bIn),
    .resVec (result)
  );

endmodule

// File: rtl/lanePermAdd_chk.sv
module lanePermAdd_chk #(
  parameter int DATA_W   = 32,
  parameter int NUM_ROWS = 4
) (
  input logic clk,
  input logic rstN,
  input logic inValid,
  input logic [3:0] pattern,
  input logic fuseAdd,
  input logic [NUM_ROWS*16*DATA_W-1:0] bIn,
  input logic [NUM_ROWS*16*DATA_W-1:0] result,
  input logic outValid
);

  localparam int LANES = NUM_ROWS * 16;
  localparam int HALF  = LANES / 2;

  // R2
  valid_follows_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  // R2
  result_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(result));

  // R6
  share_uniform_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !fuseAdd && pattern == 4'd4) |=>
      result[0 +: DATA_W] == result[15*DATA_W +: DATA_W]);

  // R7
  mirror_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !fuseAdd && pattern == 4'd5) |=>
      result[0 +: DATA_W] == $past(bIn[15*DATA_W +: DATA_W]));

  // R8
  half_bcast_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !fuseAdd && pattern == 4'd8) |=>
      result[(LANES-1)*DATA_W +: DATA_W] == $past(bIn[(HALF-1)*DATA_W +: DATA_W]));

  // R10
  wave_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !fuseAdd && pattern == 4'd11) |=>
      result[0 +: DATA_W] == $past(bIn[(LANES-1)*DATA_W +: DATA_W]));

endmodule

bind lanePermAdd lanePermAdd_chk #(.DATA_W(DATA_W), .NUM_ROWS(NUM_ROWS)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .pattern  (pattern),
  .fuseAdd  (fuseAdd),
  .bIn      (bIn),
  .result   (result),
  .outValid (outValid)
);

// File: tb/lanePermAdd_test.sv
`timescale 1ns/1ps
module lanePermAdd_test;

  localparam int W     = 32;
  localparam int ROWS  = 4;
  localparam int LANES = ROWS * 16;
  localparam int VW    = LANES * W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [3:0] pattern = '0;
  logic [7:0] patArg = '0;
  logic fuseAdd = 1'b0;
  logic [VW-1:0] aIn = '0;
  logic [VW-1:0] bIn = '0;
  logic [VW-1:0] result;
  logic outValid;

  int nChecks = 0;
  int nFails  = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  lanePermAdd #(.DATA_W(W), .NUM_ROWS(ROWS)) uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .pattern(pattern),
    .patArg(patArg), .fuseAdd(fuseAdd), .aIn(aIn), .bIn(bIn),
    .result(result), .outValid(outValid)
  );

  // Source lane per requirement R3..R12.
  function automatic int srcLane(int code, int arg, int lane);
    int r = (lane / 16) * 16;
    int p = lane % 16;
    int n = arg & 15;
    case (code)
      0:  return (lane / 4) * 4 + ((arg >> (2 * (lane % 4))) & 3);
      1:  return (p < n) ? lane : lane - n;
      2:  return (p + n > 15) ? lane : lane + n;
      3:  return r + (p + 16 - n) % 16;
      4:  return r + n;
      5:  return r + 15 - p;
      6:  return (lane / 8) * 8 + 7 - (lane % 8);
      7:  return (lane < 16) ? lane : r - 1;
      8:  return (lane < LANES / 2) ? lane : LANES / 2 - 1;
      9:  return (lane == 0) ? 0 : lane - 1;
      10: return (lane == LANES - 1) ? lane : lane + 1;
      11: return (lane == 0) ? LANES - 1 : lane - 1;
      12: return (lane == LANES - 1) ? 0 : lane + 1;
      default: return lane;
    endcase
  endfunction

  task automatic checkVec(string req, logic [VW-1:0] exp);
    nChecks++;
    if (result !== exp) begin
      nFails++;
      for (int l = 0; l < LANES; l++) begin
        if (result[l*W +: W] !== exp[l*W +: W]) begin
          $display("FAIL %s lane %0d actual %h expected %h", req, l,
                   result[l*W +: W], exp[l*W +: W]);
          break;
        end
      end
    end
  endtask

  task automatic checkBit(string req, logic act, logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic fillOperands(logic [W-1:0] aBase, logic [W-1:0] aStep);
    for (int l = 0; l < LANES; l++) begin
      bIn[l*W +: W] = 32'hB000_0000 + W'(l * 3 + 7);
      aIn[l*W +: W] = aBase + aStep * W'(l);
    end
  endtask

  task automatic applyOp(int code, int arg, bit fuse);
    @(negedge clk);
    pattern = 4'(code);
    patArg  = 8'(arg);
    fuseAdd = fuse;
    inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic runPattern(string req, int code, int arg, bit fuse);
    logic [VW-1:0] exp;
    for (int l = 0; l < LANES; l++) begin
      exp[l*W +: W] = bIn[srcLane(code, arg, l)*W +: W];
      if (fuse) exp[l*W +: W] = exp[l*W +: W] + aIn[l*W +: W];
    end
    applyOp(code, arg, fuse);
    checkVec(req, exp);
  endtask

  task automatic testReset();
    fillOperands(32'h0, 32'h1);
    inValid = 1'b1;
    repeat (3) @(negedge clk);
    checkVec("R1", '0);
    checkBit("R1 outValid", outValid, 1'b0);
    inValid = 1'b0;
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic testLatency();
    logic [VW-1:0] held;
    fillOperands(32'h0, 32'h0);
    runPattern("R2 capture", 15, 0, 1'b0);
    checkBit("R2 outValid high", outValid, 1'b1);
    held = result;
    bIn = ~bIn;
    pattern = 4'd5;
    @(negedge clk);
    @(negedge clk);
    checkVec("R2 hold", held);
    checkBit("R2 outValid low", outValid, 1'b0);
  endtask

  task automatic testQuad();
    fillOperands(32'h0, 32'h0);
    runPattern("R3 quad 2301", 0, 8'h4E, 1'b0);
    runPattern("R3 quad 3300", 0, 8'h0F, 1'b0);
    fillOperands(32'h1000_0000, 32'h0001_0000);
    runPattern("R11 quad 2301 fused", 0, 8'h4E, 1'b1);
  endtask

  task automatic testRowShift();
    fillOperands(32'h0, 32'h0);
    runPattern("R4 row up 3", 1, 3, 1'b0);
    runPattern("R4 row down 5", 2, 5, 1'b0);
    runPattern("R4 row up 15", 1, 15, 1'b0);
    runPattern("R5 row rotate 6", 3, 6, 1'b0);
    runPattern("R5 row rotate 15", 3, 15, 1'b0);
  endtask

  task automatic testShareMirror();
    fillOperands(32'h0, 32'h0);
    runPattern("R6 share 9", 4, 9, 1'b0);
    runPattern("R6 share 15", 4, 15, 1'b0);
    runPattern("R7 row mirror", 5, 0, 1'b0);
    runPattern("R7 octet mirror", 6, 0, 1'b0);
  endtask

  task automatic testBroadcast();
    fillOperands(32'h0, 32'h0);
    runPattern("R8 row-to-row", 7, 0, 1'b0);
    runPattern("R8 half-to-half", 8, 0, 1'b0);
  endtask

  task automatic testWave();
    fillOperands(32'h0, 32'h0);
    runPattern("R9 wave up", 9, 0, 1'b0);
    runPattern("R9 wave down", 10, 0, 1'b0);
    runPattern("R10 wave rotate up", 11, 0, 1'b0);
    runPattern("R10 wave rotate down", 12, 0, 1'b0);
  endtask

  task automatic testAddWrap();
    fillOperands(32'hFFFF_FFFF, 32'h0);
    runPattern("R11 wrap", 9, 0, 1'b1);
    fillOperands(32'h8000_0000, 32'h0100_0000);
    runPattern("R11 rotate fused", 3, 1, 1'b1);
  endtask

  task automatic testUndefined();
    fillOperands(32'h0, 32'h0);
    runPattern("R12 code13", 13, 8'hFF, 1'b0);
    runPattern("R12 code14", 14, 8'h4E, 1'b0);
  endtask

  initial begin
    testReset();
    testLatency();
    testQuad();
    testRowShift();
    testShareMirror();
    testBroadcast();
    testWave();
    testAddWrap();
    testUndefined();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

endmodule